// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

A storage register of parameterised width that, on each rising clock edge, keeps its contents, moves them one place toward the top bit, moves them one place toward bit 0, or captures a parallel word. A two-bit select picks the operation. An active-low synchronous clear overrides the select and empties the register. The parallel word arrives on the same data port that the register uses to show its contents. That port is modelled as three signals: an input word, an output word and one drive enable.

The output side of the port drives only when both active-low enables are asserted and the select is not the capture code. The capture code floats the port by itself, so the external word can be sampled. Turning the enables off has no effect on the stored value. Two single-bit taps always show bit 0 and the top bit. Chaining a tap of one unit into the serial input of its neighbour forms longer shifters.

Top module: `ushift_bidir_reg`

## Requirements
- R1: sel = 2'b00 keeps the stored word unchanged across the clock edge.
- R2: sel = 2'b01 moves every bit i to bit i+1 and loads ser_up_in into bit 0 on the clock edge.
- R3: sel = 2'b10 moves every bit i to bit i-1 and loads ser_down_in into the top bit (WIDTH-1) on the clock edge.
- R4: sel = 2'b11 stores data_in on the clock edge.
- R5: clr_n low at a rising edge stores all zeros, whatever sel holds. Nothing else clears the register.
- R6: data_oe is 1 exactly when oe_a_n = 0, oe_b_n = 0 and sel is not 2'b11. While data_oe is 1, data_out equals the stored word. Otherwise data_out is all zeros.
- R7: oe_a_n and oe_b_n have no effect on clearing, shifting, keeping or loading.
- R8: tap_lo equals stored bit 0 and tap_hi equals the stored top bit at all times, whatever the enables and the select.
- R9: When the tap_hi of a low unit feeds the ser_up_in of a high unit, and the tap_lo of the high unit feeds the ser_down_in of the low unit, the pair behaves as one register twice as wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| sel | input | 2 | Operation select: keep, up, down, capture |
| oe_a_n | input | 1 | Port enable A, active low |
| oe_b_n | input | 1 | Port enable B, active low |
| ser_up_in | input | 1 | Serial bit entering bit 0 on an up move |
| ser_down_in | input | 1 | Serial bit entering the top bit on a down move |
| data_in | input | WIDTH | Word the port sees, captured with sel = 2'b11 |
| data_out | output | WIDTH | Word the port drives, all zeros when floating |
| data_oe | output | 1 | Port drive enable, 1 means driven |
| tap_lo | output | 1 | Stored bit 0, always valid |
| tap_hi | output | 1 | Stored top bit, always valid |

## Verification
The bench builds two units at the default width of 8 and chains them through their taps into one 16-bit shifter. This makes the crossing between units at bits 7 and 8 part of every up and down move, in both directions. Random sequences that mix clears, captures, moves and enable settings are compared with a 16-bit model. Directed runs fill and drain the whole chain through both serial inputs, clear with the capture code applied, and move the data while the port floats.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shift_mode_e;

  // Next value of one storage bit; clear overrides every mode.
  function automatic logic stage_next(input logic        clear,
                                      input shift_mode_e mode,
                                      input logic        cur,
                                      input logic        below,
                                      input logic        above,
                                      input logic        par);
    logic nxt;
    if (clear) begin
      nxt = 1'b0;
    end else begin
      case (mode)
        MODE_KEEP: nxt = cur;
        MODE_UP:   nxt = below;
        MODE_DOWN: nxt = above;
        default:   nxt = par;
      endcase
    end
    return nxt;
  endfunction

  // The port drives only with both enables asserted and no capture pending.
  function automatic logic port_enabled(input shift_mode_e mode,
                                        input logic        en_a_n,
                                        input logic        en_b_n);
    return !en_a_n && !en_b_n && (mode != MODE_LOAD);
  endfunction

endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
  import ushift_pkg::*;
(
  input  logic [1:0]  sel,
  input  logic        clr_n,
  input  logic        oe_a_n,
  input  logic        oe_b_n,
  output shift_mode_e mode,
  output logic        clear_ev,
  output logic        port_drive
);

  always_comb begin
    mode       = shift_mode_e'(sel);
    clear_ev   = !clr_n;
    port_drive = port_enabled(mode, oe_a_n, oe_b_n);
  end

endmodule

// File: rtl/ushift_stage_bank.sv
module ushift_stage_bank
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear,
  input  shift_mode_e      mode,
  input  logic             ser_up_in,
  input  logic             ser_down_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_first
      assign from_below = ser_up_in;
    end else begin : g_inner_lo
      assign from_below = q[i-1];
    end
    if (i == MSB) begin : g_last
      assign from_above = ser_down_in;
    end else begin : g_inner_hi
      assign from_above = q[i+1];
    end
    assign nxt[i] = stage_next(clear, mode, q[i], from_below, from_above, par_in[i]);
  end

  always_ff @(posedge clk) begin
    q <= nxt;
  end

endmodule

// File: rtl/ushift_port_drv.sv
module ushift_port_drv #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q,
  input  logic             port_drive,
  output logic [WIDTH-1:0] data_out,
  output logic             data_oe
);

  always_comb begin
    data_oe  = port_drive;
    data_out = port_drive ? q : '0;
  end

endmodule

// File: rtl/ushift_bidir_reg.sv
module ushift_bidir_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       sel,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_up_in,
  input  logic             ser_down_in,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out,
  output logic             data_oe,
  output logic             tap_lo,
  output logic             tap_hi
);

  localparam int MSB = WIDTH - 1;

  shift_mode_e      mode;
  logic             clear_ev;
  logic             port_drive;
  logic [WIDTH-1:0] state_q;

  ushift_ctrl u_ctrl (
    .sel        (sel),
    .clr_n      (clr_n),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .mode       (mode),
    .clear_ev   (clear_ev),
    .port_drive (port_drive)
  );

  ushift_stage_bank #(.WIDTH(WIDTH)) u_bank (
    .clk         (clk),
    .clear       (clear_ev),
    .mode        (mode),
    .ser_up_in   (ser_up_in),
    .ser_down_in (ser_down_in),
    .par_in      (data_in),
    .q           (state_q)
  );

  ushift_port_drv #(.WIDTH(WIDTH)) u_port (
    .q          (state_q),
    .port_drive (port_drive),
    .data_out   (data_out),
    .data_oe    (data_oe)
  );

  assign tap_lo = state_q[0];
  assign tap_hi = state_q[MSB];

endmodule

// File: rtl/ushift_bidir_reg_chk.sv
module ushift_bidir_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic [1:0]       sel,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic             ser_up_in,
  input logic             ser_down_in,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] data_out,
  input logic             data_oe,
  input logic             tap_lo,
  input logic             tap_hi,
  input logic [WIDTH-1:0] state_q
);

  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b00) |=> $stable(state_q)); // R1

  AST_UP_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b01) |=> state_q == {$past(state_q[WIDTH-2:0]), $past(ser_up_in)}); // R2

  AST_DOWN_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b10) |=> state_q == {$past(ser_down_in), $past(state_q[WIDTH-1:1])}); // R3

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b11) |=> state_q == $past(data_in)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> state_q == '0); // R5

  AST_LOAD_FLOATS: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b11) |-> !data_oe && data_out == '0); // R6

  AST_OFF_FLOATS: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n || oe_b_n) |-> !data_oe && data_out == '0); // R6

  AST_ON_SHOWS: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_a_n && !oe_b_n && sel != 2'b11) |-> data_oe && data_out == state_q); // R6

  AST_TAP_LO_ENTRY: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b01) |=> tap_lo == $past(ser_up_in)); // R8

  AST_TAP_HI_ENTRY: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b10) |=> tap_hi == $past(ser_down_in)); // R8

endmodule

bind ushift_bidir_reg ushift_bidir_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .clr_n       (clr_n),
  .sel         (sel),
  .oe_a_n      (oe_a_n),
  .oe_b_n      (oe_b_n),
  .ser_up_in   (ser_up_in),
  .ser_down_in (ser_down_in),
  .data_in     (data_in),
  .data_out    (data_out),
  .data_oe     (data_oe),
  .tap_lo      (tap_lo),
  .tap_hi      (tap_hi),
  .state_q     (state_q)
);

// File: tb/ushift_bidir_reg_bench.sv
`timescale 1ns/1ps
module ushift_bidir_reg_bench;

  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        oe_a_n = 1'b1;
  logic        oe_b_n = 1'b1;
  logic        ser_up = 1'b0;
  logic        ser_dn = 1'b0;
  logic [15:0] din = '0;

  logic [7:0]  lo_out, hi_out;
  logic        lo_oe, hi_oe;
  logic        lo_tap_lo, lo_tap_hi, hi_tap_lo, hi_tap_hi;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  ushift_bidir_reg u_ushift_bidir_reg (
    .clk(clk), .clr_n(clr_n), .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_up_in(ser_up), .ser_down_in(hi_tap_lo), .data_in(din[7:0]),
    .data_out(lo_out), .data_oe(lo_oe), .tap_lo(lo_tap_lo), .tap_hi(lo_tap_hi)
  );

  ushift_bidir_reg u_ushift_bidir_reg_hi (
    .clk(clk), .clr_n(clr_n), .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_up_in(lo_tap_hi), .ser_down_in(ser_dn), .data_in(din[15:8]),
    .data_out(hi_out), .data_oe(hi_oe), .tap_lo(hi_tap_lo), .tap_hi(hi_tap_hi)
  );

  logic [15:0] model = '0;
  bit          model_ok = 1'b0;
  string       last_tag = "R5";

  function automatic logic [15:0] model_next(input logic [15:0] s, input bit c,
      input logic [1:0] md, input bit su, input bit sd, input logic [15:0] d);
    if (!c) return 16'h0000;
    case (md)
      2'b00:   return s;
      2'b01:   return {s[14:0], su};
      2'b10:   return {sd, s[15:1]};
      default: return d;
    endcase
  endfunction

  function automatic bit expect_oe(input bit a, input bit b, input logic [1:0] md);
    return !a && !b && (md != 2'b11);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit eo;
    eo = expect_oe(oe_a_n, oe_b_n, sel);
    chk("R6 oe", {14'd0, hi_oe, lo_oe}, {14'd0, eo, eo});
    chk(eo ? {"R6 ", last_tag} : "R6 float", {hi_out, lo_out}, eo ? model : 16'h0000);
    chk({"R8 ", last_tag}, {14'd0, hi_tap_hi, lo_tap_lo}, {14'd0, model[15], model[0]});
    chk({"R9 ", last_tag}, {14'd0, hi_tap_lo, lo_tap_hi}, {14'd0, model[8], model[7]});
  endtask

  task automatic step(input bit c, input logic [1:0] md, input bit a, input bit b,
                      input bit su, input bit sd, input logic [15:0] d);
    @(negedge clk);
    clr_n = c; sel = md; oe_a_n = a; oe_b_n = b; ser_up = su; ser_dn = sd; din = d;
    #1;
    if (model_ok) check_outputs();
    model = model_next(model, c, md, su, sd, d);
    if (!c) model_ok = 1'b1;
    if (!c) last_tag = "R5";
    else if ((a || b) && md != 2'b11) last_tag = "R7";
    else case (md)
      2'b00: last_tag = "R1";
      2'b01: last_tag = "R2";
      2'b10: last_tag = "R3";
      default: last_tag = "R4";
    endcase
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0323));
    // Clear with capture code and disabled port: clear wins (R5)
    step(1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF);
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF);
    // Capture with enables asserted: port floats (R4, R6)
    step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3);
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    // Moves while the port is disabled still happen (R7)
    step(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
    step(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000);
    step(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000);
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    // Fill the chain from bit 0 and drain it toward bit 0 (R2, R3, R9)
    for (int i = 0; i < 16; i++) step(1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
    for (int i = 0; i < 16; i++) step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, i[0], 16'h0000);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 16) != 0, 2'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
           1'($urandom), 1'($urandom), 16'($urandom));
    end
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule